// File: doc/BRIEF.md
# Registered Sum-of-Products Logic Array

This block models a small programmable AND-OR logic device in plain synthesizable logic. A 2048-entry fuse map configures a 64-row by 32-column AND array. The columns are the true and inverted forms of sixteen array inputs. Eight output cells each take a group of eight adjacent product terms. Each cell either registers the OR of its terms on the clock, or drives it straight out under a per-cell enable term. The pin value of every cell is the inverse of its sum.

The map is written only while `cfg_mode` is high. It can be written a whole row at a time or streamed one bit per cycle. During configuration all outputs are off and every register is held at its preset.

The parameter `REG_COUNT` selects 0, 4, 6 or 8 registered cells. The registered cells are always the central ones. The remaining cells are combinational and take their array feedback from the sensed pad level, so a cell that is switched off acts as an extra input. The pad ring around the block is expected to return the resolved pad level on `pin_in`.

Top module: `pal_top`

## Requirements
- R1: Fuse n belongs to row n/32 and column n%32. Column 2k carries array input k and column 2k+1 carries its inverse. A word write to row r loads data bit c into fuse 32r+c.
- R2: A fuse at 1 connects its column to the row. A row with both polarities of any input connected is always false. Reset sets every fuse to 1, so every term is false after reset.
- R3: A row with no connected fuse is always true.
- R4: On a combinational cell m, `out_en[m]` is term 8m and `out_val[m]` is the inverse of the OR of terms 8m+1 to 8m+7.
- R5: On a registered cell m, the state takes the OR of terms 8m to 8m+7 at each rising clock edge. `out_val[m]` is the inverse of the state, and `out_en[m]` is the inverse of `oe_n`.
- R6: Reset, and every clock edge with `cfg_mode` high, preset all register states to 1, so registered `out_val` bits read 0.
- R7: Array inputs 0 to 7 are `ded_in[7:0]`. Array input 8+m is the feedback of cell m: the state of a registered cell, or `pin_in[m]` for a combinational cell. With REG_COUNT 0, array inputs 8 and 15 are `ded_in[8]` and `ded_in[9]` instead.
- R8: The registered cells are indices (8-REG_COUNT)/2 up to (8-REG_COUNT)/2+REG_COUNT-1. With REG_COUNT 4 these are cells 2 to 5.
- R9: On each cycle in configuration with `cfg_ser_en` high, `cfg_ser_bit` is written to the fuse at a bit pointer, and the pointer then advances by one. The pointer is 0 at the first cycle of every configuration session.
- R10: Word and serial writes outside configuration are ignored. All `out_en` bits are 0 while `cfg_mode` is high. A word write takes priority over a serial write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration session active |
| cfg_wr_en | input | 1 | Word write strobe |
| cfg_wr_row | input | 6 | Row addressed by a word write |
| cfg_wr_data | input | 32 | Fuse values for the addressed row, bit c = column c |
| cfg_ser_en | input | 1 | Serial write strobe |
| cfg_ser_bit | input | 1 | Fuse value for the serial pointer |
| ded_in | input | 10 | Dedicated inputs; bits 9:8 used only with REG_COUNT 0 |
| oe_n | input | 1 | Active-low enable for registered cells |
| pin_in | input | 8 | Sensed pad level per cell |
| out_val | output | 8 | Value each cell drives |
| out_en | output | 8 | Drive enable per cell |

## Verification
The bench sweeps all 1024 dedicated-input codes against several fuse maps, for both a four-register and a register-free build, and compares both against an arithmetic model.

Contradiction rows and empty rows are placed in the maps. A design that handled them wrongly would invert a whole cell. Some serial sessions stop partway through a row. A pointer that fails to restart would put a later session's bits into the wrong row, and the stale row would show up in the sweep.

Writes held active outside configuration would corrupt a term that is visible on an output. A missing preset on configuration entry would leave registered pins at their old level on the first vector after the session.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int N_IN        = 16;
    localparam int N_COL       = 2 * N_IN;
    localparam int N_MC        = 8;
    localparam int ROWS_PER_MC = 8;
    localparam int N_ROW       = N_MC * ROWS_PER_MC;
    localparam int N_FUSE      = N_ROW * N_COL;
    localparam int N_CORE_IN   = N_IN - N_MC;
    localparam int N_DED       = N_CORE_IN + 2;
    localparam int ROW_W       = $clog2(N_ROW);
    localparam int COL_W       = $clog2(N_COL);
    localparam int PTR_W       = $clog2(N_FUSE);

    typedef logic [N_COL-1:0] fuse_row_t;
    typedef logic [N_ROW-1:0][N_COL-1:0] fuse_map_t;

    typedef enum logic {
        CELL_COMB = 1'b0,
        CELL_REG  = 1'b1
    } cell_kind_e;

    typedef struct packed {
        logic             wr_en;
        logic [ROW_W-1:0] wr_row;
        fuse_row_t        wr_data;
        logic             ser_en;
        logic             ser_bit;
    } cfg_req_t;

    typedef struct packed {
        logic val;
        logic en;
    } pin_drv_t;

    // Registered cells sit in the middle of the cell row.
    function automatic bit cell_is_reg(int m, int reg_count);
        int first;
        first = (N_MC - reg_count) / 2;
        return (m >= first) && (m < first + reg_count);
    endfunction

    function automatic logic [N_MC-1:0] reg_mask(int reg_count);
        logic [N_MC-1:0] mask;
        for (int m = 0; m < N_MC; m++) mask[m] = cell_is_reg(m, reg_count);
        return mask;
    endfunction

    // Even column: true input, odd column: inverted input.
    function automatic fuse_row_t literals(logic [N_IN-1:0] ai);
        fuse_row_t lit;
        for (int k = 0; k < N_IN; k++) begin
            lit[2*k]   = ai[k];
            lit[2*k+1] = ~ai[k];
        end
        return lit;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_mode,
    input  cfg_req_t         req,
    output fuse_map_t        fuse_map,
    output logic [PTR_W-1:0] ser_ptr
);

    fuse_map_t        fuse_q;
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q <= '1;
            ptr_q  <= '0;
        end else if (!cfg_mode) begin
            ptr_q <= '0;
        end else if (req.wr_en) begin
            fuse_q[req.wr_row] <= req.wr_data;
        end else if (req.ser_en) begin
            fuse_q[ptr_q[PTR_W-1:COL_W]][ptr_q[COL_W-1:0]] <= req.ser_bit;
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    assign fuse_map = fuse_q;
    assign ser_ptr  = ptr_q;

endmodule

// File: rtl/pal_and_array.sv
module pal_and_array
    import pal_pkg::*;
(
    input  fuse_map_t        fuse_map,
    input  logic [N_IN-1:0]  array_in,
    output logic [N_ROW-1:0] terms
);

    fuse_row_t lit;

    assign lit = literals(array_in);

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        // A connected column must be 1; unconnected columns pass.
        assign terms[r] = &(lit | ~fuse_map[r]);
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_COMB
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_mode,
    input  logic                   oe_n,
    input  logic [ROWS_PER_MC-1:0] terms,
    input  logic                   pin_in,
    output pin_drv_t               drv,
    output logic                   fb
);

    localparam bit IS_REG = (KIND == CELL_REG);

    logic sum_all;
    logic sum_data;
    logic state_q;

    assign sum_all  = |terms;
    assign sum_data = |terms[ROWS_PER_MC-1:1];

    always_ff @(posedge clk) begin
        if (rst || cfg_mode) state_q <= 1'b1;
        else                 state_q <= sum_all;
    end

    always_comb begin
        drv.val = IS_REG ? ~state_q : ~sum_data;
        drv.en  = cfg_mode ? 1'b0 : (IS_REG ? ~oe_n : terms[0]);
    end

    assign fb = IS_REG ? state_q : pin_in;

endmodule

// File: rtl/pal_top.sv
module pal_top
    import pal_pkg::*;
#(
    parameter int REG_COUNT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_mode,
    input  logic         cfg_wr_en,
    input  logic [5:0]   cfg_wr_row,
    input  logic [31:0]  cfg_wr_data,
    input  logic         cfg_ser_en,
    input  logic         cfg_ser_bit,
    input  logic [9:0]   ded_in,
    input  logic         oe_n,
    input  logic [7:0]   pin_in,
    output logic [7:0]   out_val,
    output logic [7:0]   out_en
);

    localparam bit OUTER_AS_IN = (REG_COUNT == 0);

    cfg_req_t         req;
    fuse_map_t        fuse_map;
    logic [PTR_W-1:0] ser_ptr;
    logic [N_IN-1:0]  array_in;
    logic [N_ROW-1:0] terms;
    logic [N_MC-1:0]  fb;
    pin_drv_t         drv [N_MC];

    assign req = '{wr_en:   cfg_wr_en,
                   wr_row:  cfg_wr_row,
                   wr_data: cfg_wr_data,
                   ser_en:  cfg_ser_en,
                   ser_bit: cfg_ser_bit};

    pal_fuse_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .req      (req),
        .fuse_map (fuse_map),
        .ser_ptr  (ser_ptr)
    );

    assign array_in[N_CORE_IN-1:0] = ded_in[N_CORE_IN-1:0];

    for (genvar m = 0; m < N_MC; m++) begin : g_fb
        if (m == 0) begin : g_lo
            assign array_in[N_CORE_IN+m] = OUTER_AS_IN ? ded_in[N_CORE_IN] : fb[m];
        end else if (m == N_MC-1) begin : g_hi
            assign array_in[N_CORE_IN+m] = OUTER_AS_IN ? ded_in[N_CORE_IN+1] : fb[m];
        end else begin : g_mid
            assign array_in[N_CORE_IN+m] = fb[m];
        end
    end

    pal_and_array u_array (
        .fuse_map (fuse_map),
        .array_in (array_in),
        .terms    (terms)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_cell
        localparam cell_kind_e KIND = cell_is_reg(m, REG_COUNT) ? CELL_REG : CELL_COMB;
        pal_macrocell #(.KIND(KIND)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .cfg_mode (cfg_mode),
            .oe_n     (oe_n),
            .terms    (terms[m*ROWS_PER_MC +: ROWS_PER_MC]),
            .pin_in   (pin_in[m]),
            .drv      (drv[m]),
            .fb       (fb[m])
        );
        assign out_val[m] = drv[m].val;
        assign out_en[m]  = drv[m].en;
    end

endmodule

// File: rtl/pal_top_chk.sv
module pal_top_chk
    import pal_pkg::*;
#(
    parameter int REG_COUNT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_mode,
    input logic             cfg_wr_en,
    input logic             cfg_ser_en,
    input logic             oe_n,
    input logic [7:0]       out_val,
    input logic [7:0]       out_en,
    input logic [N_ROW-1:0] terms,
    input fuse_map_t        fuse_map,
    input logic [PTR_W-1:0] ser_ptr
);

    localparam logic [N_MC-1:0] REG_MASK = reg_mask(REG_COUNT);

    a_r10_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> (out_en == '0));

    a_r10_map_frozen: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(fuse_map));

    a_r6_cfg_preset: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |=> ((out_val & REG_MASK) == '0));

    a_r5_reg_enable: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |-> ((out_en & REG_MASK) == ({N_MC{~oe_n}} & REG_MASK)));

    a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && cfg_ser_en && !cfg_wr_en) |=> (ser_ptr == $past(ser_ptr) + PTR_W'(1)));

    for (genvar m = 0; m < N_MC; m++) begin : g_cell
        if (cell_is_reg(m, REG_COUNT)) begin : g_reg
            a_r5_capture: assert property (@(posedge clk) disable iff (rst)
                !cfg_mode |=> (out_val[m] == ~(|$past(terms[m*ROWS_PER_MC +: ROWS_PER_MC]))));
        end else begin : g_comb
            a_r4_comb_val: assert property (@(posedge clk) disable iff (rst)
                out_val[m] == ~(|terms[m*ROWS_PER_MC+1 +: ROWS_PER_MC-1]));
        end
    end

endmodule

bind pal_top pal_top_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_ser_en (cfg_ser_en),
    .oe_n       (oe_n),
    .out_val    (out_val),
    .out_en     (out_en),
    .terms      (terms),
    .fuse_map   (fuse_map),
    .ser_ptr    (ser_ptr)
);

// File: tb/pal_top_tb.sv
`timescale 1ns/1ps
module pal_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_mode, cfg_wr_en, cfg_ser_en, cfg_ser_bit, oe_n;
    logic [5:0]  cfg_wr_row;
    logic [31:0] cfg_wr_data;
    logic [9:0]  ded_in;
    logic [7:0]  pin_in;
    logic [7:0]  val4, en4, val0, en0;

    logic [2047:0] fm;
    logic [7:0]    q4;
    logic [31:0]   seed;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    pal_top #(.REG_COUNT(4)) u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_row(cfg_wr_row), .cfg_wr_data(cfg_wr_data), .cfg_ser_en(cfg_ser_en),
        .cfg_ser_bit(cfg_ser_bit), .ded_in(ded_in), .oe_n(oe_n), .pin_in(pin_in),
        .out_val(val4), .out_en(en4));

    pal_top #(.REG_COUNT(0)) u_dut_l (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_row(cfg_wr_row), .cfg_wr_data(cfg_wr_data), .cfg_ser_en(cfg_ser_en),
        .cfg_ser_bit(cfg_ser_bit), .ded_in(ded_in), .oe_n(oe_n), .pin_in(pin_in),
        .out_val(val0), .out_en(en0));

    task automatic next_rand(output logic [31:0] r);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        r = seed;
    endtask

    // Sparse product term: each input is absent, true or inverted.
    task automatic mk_row(output logic [31:0] d);
        logic [31:0] a, b;
        logic [63:0] bits;
        next_rand(a);
        next_rand(b);
        bits = {b, a};
        d = '0;
        for (int k = 0; k < 16; k++) begin
            if (bits[3*k +: 3] == 3'd1) d[2*k] = 1'b1;
            if (bits[3*k +: 3] == 3'd2) d[2*k+1] = 1'b1;
        end
    endtask

    // Reference model from R1..R8; cells 2..5 registered when r is 4 (R8).
    task automatic model(input int r, input logic [7:0] q,
                         output logic [7:0] v, output logic [7:0] e, output logic [7:0] nq);
        logic [15:0] ai;
        logic [63:0] t;
        logic [7:0]  rm;
        rm = (r == 4) ? 8'h3C : 8'h00;
        for (int k = 0; k < 8; k++) ai[k] = ded_in[k];
        for (int m = 0; m < 8; m++) ai[8+m] = rm[m] ? q[m] : pin_in[m];
        if (r == 0) begin
            ai[8]  = ded_in[8];
            ai[15] = ded_in[9];
        end
        for (int row = 0; row < 64; row++) begin
            t[row] = 1'b1;
            for (int c = 0; c < 32; c++)
                if (fm[row*32 + c] && ((ai[c/2] ^ c[0]) == 1'b0)) t[row] = 1'b0;
        end
        for (int m = 0; m < 8; m++) begin
            nq[m] = |t[m*8 +: 8];
            if (rm[m]) begin
                v[m] = ~q[m];
                e[m] = ~oe_n;
            end else begin
                v[m] = ~(|t[m*8+1 +: 7]);
                e[m] = t[m*8];
            end
            if (cfg_mode) e[m] = 1'b0;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic vec(input logic [9:0] d, input logic [7:0] p, input logic o, input string req);
        logic [7:0] v, e, nq, v0, e0, nq0;
        ded_in = d; pin_in = p; oe_n = o;
        #1;
        model(4, q4, v, e, nq);
        model(0, 8'h00, v0, e0, nq0);
        chk(req, val4, v);
        chk(req, en4, e);
        chk(req, val0, v0);
        chk(req, en0, e0);
        @(posedge clk);
        q4 = nq;
        @(negedge clk);
    endtask

    task automatic sweep(input int n, input string req);
        logic [31:0] r;
        for (int i = 0; i < n; i++) begin
            next_rand(r);
            vec(i[9:0], r[7:0], r[8], req);
        end
    endtask

    task automatic word_write(input logic [5:0] row, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_row = row; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (cfg_mode) fm[row*32 +: 32] = data;
    endtask

    task automatic ser_write(input int idx, input logic b);
        cfg_ser_en = 1'b1; cfg_ser_bit = b;
        @(negedge clk);
        cfg_ser_en = 1'b0;
        fm[idx] = b;
    endtask

    task automatic enter_cfg();
        cfg_mode = 1'b1;
        #1;
        chk("R10 enables off in config", en4, 8'h00);
        chk("R10 enables off in config", en0, 8'h00);
    endtask

    task automatic exit_cfg();
        @(negedge clk);
        cfg_mode = 1'b0;
        q4 = 8'hFF;
        #1;
        chk("R6 preset after config", val4 & 8'h3C, 8'h00);
    endtask

    task automatic run_all();
        logic [31:0] d;
        logic [31:0] newrow;
        logic [2047:0] mapb;
        rst = 1'b1; cfg_mode = 0; cfg_wr_en = 0; cfg_ser_en = 0; cfg_ser_bit = 0;
        cfg_wr_row = '0; cfg_wr_data = '0; ded_in = '0; pin_in = '0; oe_n = 1'b0;
        seed = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        fm = '1;
        q4 = 8'hFF;
        // R2 R6: reset state, all terms false
        sweep(16, "R2 R6 reset state");

        // Map A by word writes (R1), with an empty row (R3) and a contradiction row (R2)
        enter_cfg();
        for (int row = 0; row < 64; row++) begin
            mk_row(d);
            if (row == 8 || row == 9) d = '0;
            if (row == 10) d = 32'h0000_0003;
            word_write(row[5:0], d);
        end
        exit_cfg();
        sweep(1024, "R1 R2 R3 R4 R5 R7 R8 word map");

        // R10: writes held active outside configuration are ignored
        cfg_wr_en = 1'b1; cfg_wr_row = 6'd3; cfg_wr_data = '0;
        cfg_ser_en = 1'b1; cfg_ser_bit = 1'b0;
        sweep(64, "R10 writes ignored");
        cfg_wr_en = 1'b0; cfg_ser_en = 1'b0;

        // R9: full serial load of map B
        for (int row = 0; row < 64; row++) begin
            mk_row(d);
            mapb[row*32 +: 32] = d;
        end
        enter_cfg();
        for (int n = 0; n < 2048; n++) ser_write(n, mapb[n]);
        exit_cfg();
        sweep(1024, "R9 R4 R5 serial map");

        // R9: partial session, then a new session must restart at fuse 0
        enter_cfg();
        for (int n = 0; n < 40; n++) ser_write(n, 1'b0);
        exit_cfg();
        sweep(64, "R9 partial session");
        mk_row(newrow);
        enter_cfg();
        for (int n = 0; n < 32; n++) ser_write(n, newrow[n]);
        exit_cfg();
        sweep(256, "R9 pointer restart");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired at %0t", $time);
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule